// File: doc/BRIEF.md
# Cyclic Shift-Switch Broadcast Array

This block is a chain of W²−1 one-bit shift switches sitting on a W-line bus that carries data in one direction only. W is a small power of two. Each switch has a single control bit. When the bit is clear, the switch passes the bus straight through. When it is set, the switch rotates the bus cyclically up by one line. A one-hot token is taken from a buffer input and sent through the whole chain. The line the token occupies after switch j is the running count, modulo W, of the buffer value plus every control bit up to and including switch j. A switch that moves the token from the top line back to line 0 raises its carry bit. The carries are OR-combined per group of W switches. The count of carries gives the quotient of the total by W.

A single-cycle start pulse launches a broadcast. One cycle later the block registers the following results and raises `done_o`:

- the signal seen after every switch;
- the binary line index at every position;
- the per-switch carries;
- the group ORs.

If the buffer is not one-hot at start, the block raises `err_o` instead and keeps its previous results.

Top module: `shift_bcast_array`

## Requirements
- R1: After reset, `done_o`, `err_o`, `tap_o`, `digit_o`, `rot_o` and `grp_o` are all zero.
- R2: A switch with control bit 0 passes the bus unchanged. A switch with control bit 1 moves line k to line k+1, and the top line W−1 to line 0.
- R3: After a broadcast, `tap_o[j*W +: W]` is one-hot on line (b + st[0] + … + st[j]) mod W, where b is the buffer's line index and st is `state_i`.
- R4: `rot_o[j]` is 1 exactly when `state_i[j]` is 1 and the token enters switch j on line W−1.
- R5: Group 0 is switches 0 to W−2. Group g (1 ≤ g ≤ W−1) is switches g·W−1 to g·W+W−2. `grp_o[g-1]` is the OR of the carries of group g.
- R6: At most one carry is set within any group.
- R7: The number of set bits in `rot_o` equals floor((b + popcount(state_i)) / W). When the buffer encodes zero (only line 0 set), it also equals the number of set bits in `grp_o`.
- R8: `digit_o[j*LW +: LW]` is the binary index of the set line in `tap_o[j*W +: W]`, where LW = log2(W).
- R9: Results and `done_o` appear one cycle after a start with a one-hot buffer. `done_o` is high for that single cycle only.
- R10: A start whose buffer has zero set bits or more than one set bit raises `err_o` for one cycle. In that case `done_o` stays low and all result outputs keep their previous values.
- R11: Without a start, changes on `state_i` or `buf_i` leave every result output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to broadcast |
| buf_i | input | W | One-hot signal-buffer value |
| state_i | input | W*W-1 | Control bit per switch, bit j for switch j |
| tap_o | output | (W*W-1)*W | Registered signal after each switch |
| digit_o | output | (W*W-1)*log2(W) | Registered line index after each switch |
| rot_o | output | W*W-1 | Registered carry bit per switch |
| grp_o | output | W-1 | Registered OR of carries for groups 1..W-1 |
| done_o | output | 1 | Results valid pulse |
| err_o | output | 1 | Non-one-hot buffer at start |

## Verification
Assertions check several properties on every cycle:

- the one-cycle start-to-done latency;
- at most one carry per group;
- carry count equal to group-OR count for a zero buffer;
- each encoded digit pointing at the line the token sits on;
- result stability while no start is present and on an error.

The exact token position at every switch and the carry count against the arithmetic quotient can only be shown by the bench's scenarios. The same holds for the rotation direction and the group boundaries. The bench sweeps every buffer value over hundreds of control patterns and compares each against sums it computes itself.

// File: rtl/shift_bcast_pkg.sv
package shift_bcast_pkg;
    typedef enum logic {
        SW_PASS = 1'b0,
        SW_ROT  = 1'b1
    } sw_mode_e;
endpackage

// File: rtl/rot_cell.sv
module rot_cell
    import shift_bcast_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] bus_i,
    input  sw_mode_e     mode_i,
    output logic [W-1:0] bus_o,
    output logic         carry_o
);
    always_comb begin
        if (mode_i == SW_ROT) begin
            bus_o   = {bus_i[W-2:0], bus_i[W-1]};
            carry_o = bus_i[W-1];
        end else begin
            bus_o   = bus_i;
            carry_o = 1'b0;
        end
    end
endmodule

// File: rtl/tok_encoder.sv
module tok_encoder #(
    parameter int W  = 4,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  tok_i,
    output logic [LW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < W; k++) begin
            if (tok_i[k]) idx_o = idx_o | LW'(k);
        end
    end
endmodule

// File: rtl/grp_reduce.sv
module grp_reduce #(
    parameter int W = 4,
    parameter int N = W * W - 1
) (
    input  logic [N-1:0] rot_i,
    output logic [W-2:0] grp_o
);
    // Group g (g >= 1) covers switches g*W-1 .. g*W+W-2
    for (genvar g = 1; g < W; g++) begin : g_grp
        assign grp_o[g-1] = |rot_i[g*W-1 +: W];
    end
endmodule

// File: rtl/shift_bcast_array.sv
module shift_bcast_array
    import shift_bcast_pkg::*;
#(
    parameter int W  = 4,
    parameter int N  = W * W - 1,
    parameter int LW = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [W-1:0]      buf_i,
    input  logic [N-1:0]      state_i,
    output logic [N*W-1:0]    tap_o,
    output logic [N*LW-1:0]   digit_o,
    output logic [N-1:0]      rot_o,
    output logic [W-2:0]      grp_o,
    output logic              done_o,
    output logic              err_o
);
    typedef struct packed {
        logic [N*W-1:0]  tap;
        logic [N*LW-1:0] dig;
        logic [N-1:0]    rot;
        logic [W-2:0]    grp;
        logic            done;
        logic            err;
        logic            base_zero;
    } res_t;

    logic [W-1:0]    lane [0:N];
    logic [N*W-1:0]  tap_c;
    logic [N*LW-1:0] dig_c;
    logic [N-1:0]    rot_c;
    logic [W-2:0]    grp_c;
    logic            buf_ok;
    res_t            res_d, res_q;

    assign lane[0] = buf_i;

    for (genvar j = 0; j < N; j++) begin : g_sw
        rot_cell #(.W(W)) u_cell (
            .bus_i   (lane[j]),
            .mode_i  (sw_mode_e'(state_i[j])),
            .bus_o   (lane[j+1]),
            .carry_o (rot_c[j])
        );
        tok_encoder #(.W(W), .LW(LW)) u_enc (
            .tok_i (lane[j+1]),
            .idx_o (dig_c[j*LW +: LW])
        );
        assign tap_c[j*W +: W] = lane[j+1];
    end

    grp_reduce #(.W(W), .N(N)) u_grp (
        .rot_i (rot_c),
        .grp_o (grp_c)
    );

    assign buf_ok = (buf_i != '0) && ((buf_i & (buf_i - 1'b1)) == '0);

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        res_d.err  = 1'b0;
        if (start_i) begin
            if (buf_ok) begin
                res_d.tap       = tap_c;
                res_d.dig       = dig_c;
                res_d.rot       = rot_c;
                res_d.grp       = grp_c;
                res_d.done      = 1'b1;
                res_d.base_zero = buf_i[0];
            end else begin
                res_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign tap_o   = res_q.tap;
    assign digit_o = res_q.dig;
    assign rot_o   = res_q.rot;
    assign grp_o   = res_q.grp;
    assign done_o  = res_q.done;
    assign err_o   = res_q.err;

    // R9: results follow a valid start by exactly one cycle
    a_r9_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && buf_ok |=> done_o);

    // R10: an error never coincides with new results
    a_r10_err_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o && $stable(tap_o) && $stable(rot_o));

    // R11: nothing moves without a start
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> $stable(tap_o) && $stable(digit_o) && $stable(rot_o) && $stable(grp_o));

    // R7: with a zero buffer, group ORs count the carries exactly
    a_r7_grp_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && res_q.base_zero |-> $countones(rot_o) == $countones(grp_o));

    // R6: one carry at most per group
    a_r6_first_group: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones(rot_o[W-2:0]) <= 1);
    for (genvar g = 1; g < W; g++) begin : g_chk_grp
        a_r6_one_per_group: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> $countones(rot_o[g*W-1 +: W]) <= 1);
    end

    // R8: each digit points at the set line of its tap
    for (genvar j = 0; j < N; j++) begin : g_chk_dig
        a_r8_digit_points: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> tap_o[j*W + int'(digit_o[j*LW +: LW])] == 1'b1);
    end
endmodule

// File: tb/shift_bcast_array_bench.sv
`timescale 1ns/1ps
module shift_bcast_array_bench;
    localparam int W  = 4;
    localparam int N  = W * W - 1;
    localparam int LW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [W-1:0]    buf_i = '0;
    logic [N-1:0]    state_i = '0;
    logic [N*W-1:0]  tap_o;
    logic [N*LW-1:0] digit_o;
    logic [N-1:0]    rot_o;
    logic [W-2:0]    grp_o;
    logic            done_o, err_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    shift_bcast_array #(.W(W)) u_shift_bcast_array (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .buf_i(buf_i),
        .state_i(state_i), .tap_o(tap_o), .digit_o(digit_o), .rot_o(rot_o),
        .grp_o(grp_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Broadcast buffer line b with control pattern st and compare all results
    task automatic bcast(input int b, input logic [N-1:0] st);
        logic [N*W-1:0]  e_tap;
        logic [N*LW-1:0] e_dig;
        logic [N-1:0]    e_rot;
        logic [W-2:0]    e_grp;
        int s, pop;
        s = b; pop = 0;
        e_tap = '0; e_dig = '0; e_rot = '0; e_grp = '0;
        for (int j = 0; j < N; j++) begin
            e_rot[j] = st[j] && ((s % W) == W - 1);
            s = s + int'(st[j]);
            pop = pop + int'(st[j]);
            e_tap[j*W + (s % W)] = 1'b1;
            e_dig[j*LW +: LW] = LW'(s % W);
        end
        for (int g = 1; g < W; g++)
            for (int k = 0; k < W; k++)
                if (e_rot[g*W - 1 + k]) e_grp[g-1] = 1'b1;
        @(negedge clk);
        buf_i = W'(1 << b); state_i = st; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 done", 64'(done_o), 64'd1);
        chk("R3 R2 taps", 64'(tap_o), 64'(e_tap));
        chk("R8 digits", 64'(digit_o), 64'(e_dig));
        chk("R4 carries", 64'(rot_o), 64'(e_rot));
        chk("R5 group or", 64'(grp_o), 64'(e_grp));
        chk("R7 carry count", 64'($countones(rot_o)), 64'((b + pop) / W));
        if (b == 0) chk("R7 group count", 64'($countones(grp_o)), 64'(pop / W));
        @(negedge clk);
        chk("R9 done single pulse", 64'(done_o), 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [N*W-1:0] saved_tap;
        logic [N-1:0]   saved_rot;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", 64'(done_o), 64'd0);
        chk("R1 err", 64'(err_o), 64'd0);
        chk("R1 tap", 64'(tap_o), 64'd0);
        chk("R1 rot", 64'(rot_o), 64'd0);
        chk("R1 grp", 64'(grp_o), 64'd0);
        chk("R1 digit", 64'(digit_o), 64'd0);
        rst_n = 1'b1;

        // R2 corners: all pass, all rotate
        for (int b = 0; b < W; b++) begin
            bcast(b, '0);
            bcast(b, '1);
        end
        // R5 boundaries: single set bit at each position
        for (int j = 0; j < N; j++) bcast(W - 1, N'(1) << j);

        // Sweep of buffer values over pseudo-random control patterns
        lfsr = 16'hACE1;
        for (int b = 0; b < W; b++) begin
            for (int p = 0; p < 300; p++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                bcast(b, lfsr[N-1:0]);
            end
        end

        // R10: non-one-hot buffers
        bcast(1, 15'h2A5B);
        saved_tap = tap_o; saved_rot = rot_o;
        @(negedge clk);
        buf_i = 4'b0110; state_i = '1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 err multi", 64'(err_o), 64'd1);
        chk("R10 no done", 64'(done_o), 64'd0);
        chk("R10 tap kept", 64'(tap_o), 64'(saved_tap));
        chk("R10 rot kept", 64'(rot_o), 64'(saved_rot));
        buf_i = '0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 err zero", 64'(err_o), 64'd1);
        chk("R10 tap kept zero", 64'(tap_o), 64'(saved_tap));
        @(negedge clk);
        chk("R10 err single pulse", 64'(err_o), 64'd0);

        // R11: inputs change without start
        state_i = 15'h7FFF; buf_i = 4'b1000;
        repeat (3) @(negedge clk);
        state_i = 15'h1234;
        @(negedge clk);
        chk("R11 tap held", 64'(tap_o), 64'(saved_tap));
        chk("R11 rot held", 64'(rot_o), 64'(saved_rot));
        chk("R11 no done", 64'(done_o), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule